// File: doc/BRIEF.md
# LPC Host Interrupt Status and Summary Registers

This block gathers every interrupt source of an LPC host controller into one 32-bit status word with a matching mask word. It then folds the enabled, pending part of that word into a single bit of a second-level summary register set, which has its own status, mask and polarity. The bus-cycle engine reports its SYNC and turnaround errors, LPC reset and the two bus-master requests as one-cycle pulses. A serial-interrupt deserializer presents 17 slot levels. Software reaches both register sets through one 32-bit register port with a combinational read path.

The status bits for error, reset and request events are latched and write-one-to-clear. Serial-interrupt status bits are latched as well, but while their slot level is still high the latch sets again in the same cycle as a clear, so clearing succeeds only once the device has let go. A separate register records the bus address of the first SYNC error that arrives while no SYNC error is pending. The single output line is registered.

Top module: `lpc_irq_regs`

## Requirements
- R1: While reset is asserted and after it is released, every mask, polarity, status and error-address register reads 0 and `irq_o` is 0.
- R2: Serial-interrupt slot n (`serirq_i[n]`, n = 0..16) sets status bit 31-n at offset 0x38 one clock after it goes high. The bit stays set after the level falls until a 1 is written to it. A write of 1 in a cycle where the level is still high leaves the bit set.
- R3: Single-cycle pulses latch status bits as follows: `lreset_i` sets bit 10, `sync_err_i[k]` sets bit k+2 (k = 0..5), `bm_req_i[0]` sets bit 1 and `bm_req_i[1]` sets bit 0. Each bit holds until a 1 is written to it at 0x38, and writing 0 leaves it unchanged.
- R4: The controller mask at 0x34 uses the status layout. Only the implemented bits 0xFFFF84FF are stored, and every other bit reads 0.
- R5: The controller interrupt is the OR of (status AND mask). Summary status bit 11 (offset 0x50) is set one clock after the controller interrupt differs from summary polarity bit 11 (offset 0x58; 0 means active-high).
- R6: Summary status bit 11 clears on a write of 1 at 0x50 only when its set condition is inactive in that cycle. The summary mask is bit 11 at 0x54. All other summary bits read 0.
- R7: `irq_o` equals the OR of (summary status AND summary mask) delayed by exactly one clock.
- R8: The error-address register at 0x40 loads `err_addr_i` when any `sync_err_i` pulse arrives while status bits 7..2 are all clear, and otherwise holds. LPC reset and bus-master requests never load it.
- R9: Reads from unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| serirq_i | input | 17 | Deserialized serial-interrupt slot levels, index = slot |
| sync_err_i | input | 6 | SYNC/turnaround error pulses (k maps to status bit k+2) |
| lreset_i | input | 1 | LPC reset event pulse |
| bm_req_i | input | 2 | Bus-master 0/1 request pulses |
| err_addr_i | input | 32 | Bus address of the cycle reporting an error |
| irq_o | output | 1 | Registered summary interrupt line |

## Verification
The hardest case to reach is a clear of a serial-interrupt bit or of the summary bit in the same cycle as its set condition. The bench holds a slot level high across a write of ones. It also keeps a masked reset latch pending while it clears the summary bit, then repeats both clears after the source has gone. The error-address rule needs an error pulse to arrive while an earlier error is still latched. The bench sends a second pulse with a different address before clearing, and then sends non-SYNC events that must not load the register.

// File: rtl/lpc_irq_pkg.sv
package lpc_irq_pkg;
  localparam int DW          = 32;
  localparam int OFS_MASK    = 'h34;
  localparam int OFS_STAT    = 'h38;
  localparam int OFS_EADDR   = 'h40;
  localparam int OFS_SSTAT   = 'h50;
  localparam int OFS_SMASK   = 'h54;
  localparam int OFS_SPOL    = 'h58;
  localparam int SER_SLOTS   = 17;
  localparam int SER_TOP     = 31;
  localparam int N_SYNC      = 6;
  localparam int BIT_SYNC_LO = 2;
  localparam int BIT_LRST    = 10;
  localparam int BIT_BM0     = 1;
  localparam int BIT_BM1     = 0;
  localparam int BIT_CTL     = 11;
  localparam logic [DW-1:0] CTL_IMPL  = 32'hFFFF_84FF;
  localparam logic [DW-1:0] SYNC_BITS = 32'h0000_00FC;
  localparam logic [DW-1:0] SUM_IMPL  = 32'h0000_0800;
endpackage

// File: rtl/lpc_irq_w1c_bank.sv
module lpc_irq_w1c_bank #(
  parameter int               WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      logic q, d, en;
      // set wins over a simultaneous clear
      always_comb begin
        en = set_i[i] | clr_i[i];
        d  = set_i[i] | (q & ~clr_i[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= d;
      end
      assign q_o[i] = q;
    end else begin : g_tie
      logic unused_in;
      assign unused_in = set_i[i] ^ clr_i[i];
      assign q_o[i]    = 1'b0;
    end
  end
endmodule

// File: rtl/lpc_irq_rw_reg.sv
module lpc_irq_rw_reg #(
  parameter int               WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (we_i) q <= d_i[i];
      end
      assign q_o[i] = q;
    end else begin : g_tie
      logic unused_in;
      assign unused_in = d_i[i];
      assign q_o[i]    = 1'b0;
    end
  end
endmodule

// File: rtl/lpc_irq_err_addr.sv
module lpc_irq_err_addr #(
  parameter int N_ERR  = 6,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ERR-1:0]  err_i,
  input  logic              pending_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic              cap_en;
  logic [ADDR_W-1:0] addr_q;

  always_comb cap_en = (|err_i) & ~pending_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (cap_en) addr_q <= addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/lpc_irq_regs.sv
module lpc_irq_regs
  import lpc_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [SER_SLOTS-1:0] serirq_i,
  input  logic [N_SYNC-1:0] sync_err_i,
  input  logic              lreset_i,
  input  logic [1:0]        bm_req_i,
  input  logic [DW-1:0]     err_addr_i,
  output logic              irq_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // register decode
  logic sel_mask, sel_stat, sel_sstat, sel_smask, sel_spol;
  always_comb begin
    sel_mask  = reg_addr == ADDR_W'(OFS_MASK);
    sel_stat  = reg_addr == ADDR_W'(OFS_STAT);
    sel_sstat = reg_addr == ADDR_W'(OFS_SSTAT);
    sel_smask = reg_addr == ADDR_W'(OFS_SMASK);
    sel_spol  = reg_addr == ADDR_W'(OFS_SPOL);
  end

  // controller source vector
  logic [DW-1:0] ctl_set, ctl_clr, ctl_stat, ctl_mask;
  always_comb begin
    ctl_set = '0;
    for (int n = 0; n < SER_SLOTS; n++) ctl_set[SER_TOP-n] = serirq_i[n];
    ctl_set[BIT_SYNC_LO +: N_SYNC] = sync_err_i;
    ctl_set[BIT_LRST] = lreset_i;
    ctl_set[BIT_BM0]  = bm_req_i[0];
    ctl_set[BIT_BM1]  = bm_req_i[1];
    ctl_clr = (reg_we && sel_stat) ? reg_wdata : '0;
  end

  lpc_irq_w1c_bank #(.WIDTH(DW), .IMPL(CTL_IMPL)) u_ctl_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_i(ctl_set), .clr_i(ctl_clr), .q_o(ctl_stat));

  lpc_irq_rw_reg #(.WIDTH(DW), .IMPL(CTL_IMPL)) u_ctl_mask (
    .clk(clk), .rst_n(rst_sync_n), .we_i(reg_we && sel_mask), .d_i(reg_wdata), .q_o(ctl_mask));

  // first-error address
  logic [DW-1:0] err_addr_q;
  logic          sync_pending;
  always_comb sync_pending = |(ctl_stat & SYNC_BITS);

  lpc_irq_err_addr #(.N_ERR(N_SYNC), .ADDR_W(DW)) u_eaddr (
    .clk(clk), .rst_n(rst_sync_n), .err_i(sync_err_i), .pending_i(sync_pending),
    .addr_i(err_addr_i), .addr_o(err_addr_q));

  // second level summary
  logic          ctl_irq;
  logic [DW-1:0] sum_set, sum_clr, sum_stat, sum_mask, sum_pol;
  always_comb begin
    ctl_irq          = |(ctl_stat & ctl_mask);
    sum_set          = '0;
    sum_set[BIT_CTL] = ctl_irq ^ sum_pol[BIT_CTL];
    sum_clr          = (reg_we && sel_sstat) ? reg_wdata : '0;
  end

  lpc_irq_w1c_bank #(.WIDTH(DW), .IMPL(SUM_IMPL)) u_sum_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_i(sum_set), .clr_i(sum_clr), .q_o(sum_stat));

  lpc_irq_rw_reg #(.WIDTH(DW), .IMPL(SUM_IMPL)) u_sum_mask (
    .clk(clk), .rst_n(rst_sync_n), .we_i(reg_we && sel_smask), .d_i(reg_wdata), .q_o(sum_mask));

  lpc_irq_rw_reg #(.WIDTH(DW), .IMPL(SUM_IMPL)) u_sum_pol (
    .clk(clk), .rst_n(rst_sync_n), .we_i(reg_we && sel_spol), .d_i(reg_wdata), .q_o(sum_pol));

  // registered output line
  logic irq_d, irq_q, irq_en;
  always_comb begin
    irq_d  = |(sum_stat & sum_mask);
    irq_en = irq_d ^ irq_q;
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // read mux
  always_comb begin
    unique case (1'b1)
      sel_mask:                              reg_rdata = ctl_mask;
      sel_stat:                              reg_rdata = ctl_stat;
      reg_addr == ADDR_W'(OFS_EADDR):        reg_rdata = err_addr_q;
      sel_sstat:                             reg_rdata = sum_stat;
      sel_smask:                             reg_rdata = sum_mask;
      sel_spol:                              reg_rdata = sum_pol;
      default:                               reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lpc_irq_chk.sv
module lpc_irq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [16:0]       serirq_i,
  input logic [31:0]       ctl_stat,
  input logic [31:0]       ctl_mask,
  input logic [31:0]       sum_stat,
  input logic [31:0]       sum_mask,
  input logic [31:0]       sum_pol,
  input logic [31:0]       err_addr_q,
  input logic              irq_o
);
  // R2
  ser_level_sets_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    serirq_i[0] |=> ctl_stat[31]);

  // R3
  err_latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_stat[7] && !(reg_we && reg_addr == ADDR_W'('h38) && reg_wdata[7])) |=> ctl_stat[7]);

  // R8
  eaddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|ctl_stat[7:2]) |=> $stable(err_addr_q));

  // R5
  sum_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|(ctl_stat & ctl_mask)) ^ sum_pol[11]) |=> sum_stat[11]);

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sum_stat[11] && sum_mask[11]) |=> irq_o);

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(sum_stat[11] && sum_mask[11]) |=> !irq_o);
endmodule

bind lpc_irq_regs lpc_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .serirq_i(serirq_i), .ctl_stat(ctl_stat), .ctl_mask(ctl_mask),
  .sum_stat(sum_stat), .sum_mask(sum_mask), .sum_pol(sum_pol),
  .err_addr_q(err_addr_q), .irq_o(irq_o));

// File: tb/sim_lpc_irq_regs.sv
`timescale 1ns/1ps
module sim_lpc_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [16:0] serirq;
  logic [5:0]  sync_err;
  logic        lreset;
  logic [1:0]  bm_req;
  logic [31:0] err_addr;
  logic        irq_o;
  int vecs = 0;
  int bad  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lpc_irq_regs #(.ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serirq_i(serirq),
    .sync_err_i(sync_err), .lreset_i(lreset), .bm_req_i(bm_req),
    .err_addr_i(err_addr), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic drive_src(input int k, input logic v);
    if (k < 6)       sync_err[k] = v;
    else if (k == 6) lreset      = v;
    else if (k == 7) bm_req[0]   = v;
    else             bm_req[1]   = v;
  endtask

  function automatic logic [31:0] src_bit(input int k);
    if (k < 6)       return 32'h1 << (k + 2);
    else if (k == 6) return 32'h400;
    else if (k == 7) return 32'h2;
    else             return 32'h1;
  endfunction

  task automatic pulse(input int k);
    @(negedge clk); drive_src(k, 1'b1);
    @(negedge clk); drive_src(k, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    serirq = '0; sync_err = '0; lreset = 1'b0; bm_req = '0; err_addr = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    foreach (u0.reg_rdata[i]) begin end
    rdchk(8'h34, 0, "R1 mask"); rdchk(8'h38, 0, "R1 stat");
    rdchk(8'h40, 0, "R1 eaddr"); rdchk(8'h50, 0, "R1 sstat");
    rdchk(8'h54, 0, "R1 smask"); rdchk(8'h58, 0, "R1 spol");
    chk("R1 irq", {31'b0, irq_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rdchk(8'h38, 0, "R1 stat after release");
    chk("R1 irq after release", {31'b0, irq_o}, 0);

    // R2 slot sweep
    for (int n = 0; n < 17; n++) begin
      @(negedge clk); serirq[n] = 1'b1;
      rdchk(8'h38, 32'h1 << (31 - n), "R2 set");
      wr(8'h38, 32'hFFFF_FFFF);
      rdchk(8'h38, 32'h1 << (31 - n), "R2 clear while held");
      @(negedge clk); serirq[n] = 1'b0;
      rdchk(8'h38, 32'h1 << (31 - n), "R2 latched after drop");
      wr(8'h38, 32'hFFFF_FFFF);
      rdchk(8'h38, 0, "R2 cleared");
    end

    // R3 pulse source sweep
    for (int k = 0; k < 9; k++) begin
      pulse(k);
      rdchk(8'h38, src_bit(k), "R3 latch");
      wr(8'h38, ~src_bit(k));
      rdchk(8'h38, src_bit(k), "R3 write0 no effect");
      wr(8'h38, src_bit(k));
      rdchk(8'h38, 0, "R3 w1c");
    end

    // R4 mask storage
    wr(8'h34, 32'hFFFF_FFFF);
    rdchk(8'h34, 32'hFFFF_84FF, "R4 mask impl bits");
    wr(8'h34, 32'h0);
    rdchk(8'h34, 0, "R4 mask cleared");

    // R9 unmapped offsets
    rdchk(8'h3C, 0, "R9 unmapped read");
    wr(8'h3C, 32'hFFFF_FFFF);
    rdchk(8'h34, 0, "R9 unmapped write");

    // R5/R7 path timing
    wr(8'h34, 32'h400);
    wr(8'h54, 32'hFFFF_FFFF);
    rdchk(8'h54, 32'h800, "R6 smask bit");
    reg_addr = 8'h50;
    @(negedge clk); lreset = 1'b1;
    @(negedge clk); lreset = 1'b0;
    chk("R7 irq low after stat", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R5 sum set", reg_rdata, 32'h800);
    chk("R7 irq low after sum", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R7 irq high", {31'b0, irq_o}, 1);
    wr(8'h54, 32'h0);
    chk("R7 irq still high", {31'b0, irq_o}, 1);
    @(negedge clk);
    chk("R7 irq drop on mask", {31'b0, irq_o}, 0);
    wr(8'h54, 32'h800);
    // R6 clear while controller still active
    wr(8'h50, 32'h800);
    rdchk(8'h50, 32'h800, "R6 set dominates");
    wr(8'h38, 32'h400);
    rdchk(8'h50, 32'h800, "R6 holds after source gone");
    wr(8'h50, 32'h800);
    rdchk(8'h50, 0, "R6 w1c");
    chk("R7 irq low after ack", {31'b0, irq_o}, 0);

    // R5 masked status does not reach summary
    wr(8'h34, 32'h0);
    pulse(6);
    repeat (2) @(negedge clk);
    rdchk(8'h50, 0, "R5 masked");
    wr(8'h38, 32'h400);

    // R5 polarity
    wr(8'h58, 32'hFFFF_FFFF);
    rdchk(8'h58, 32'h800, "R5 pol bit");
    rdchk(8'h50, 32'h800, "R5 active low");
    wr(8'h58, 32'h0);
    wr(8'h50, 32'h800);
    rdchk(8'h50, 0, "R5 pol restored");
    wr(8'h54, 32'h0);

    // R8 first-error address
    err_addr = 32'hA5A5_0001; pulse(5);
    rdchk(8'h40, 32'hA5A5_0001, "R8 first capture");
    err_addr = 32'h1234_5678; pulse(0);
    rdchk(8'h40, 32'hA5A5_0001, "R8 hold while pending");
    wr(8'h38, 32'hFC);
    err_addr = 32'hDEAD_0002; pulse(6); pulse(7); pulse(8);
    rdchk(8'h40, 32'hA5A5_0001, "R8 non-sync ignored");
    pulse(3);
    rdchk(8'h40, 32'hDEAD_0002, "R8 recapture");
    wr(8'h38, 32'hFFFF_FFFF);
    rdchk(8'h38, 0, "R3 final clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule